// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block keeps two memory windows for one socket of a PCI-to-CardBus bridge and tells, for each incoming 32-bit PCI memory address, whether that address belongs to one of them. Each window is described by a lower bound and an upper bound. Both bounds are held in 4 KB pages and are programmed through a 32-bit configuration register port that has per-byte write enables. The upper bound is inclusive, so the last byte of a window is its limit page followed by FFFh.

An address is presented with a valid strobe. One clock later, a one-bit-per-window hit vector reports which window claims it. The hit vector is gated by a memory-space enable input. Window 0 wins when both windows cover the same address. A window whose limit page lies below its base page claims nothing. Software uses this to switch a window off.

Top module: `mwd_decoder`

## Requirements
- R1: The register offsets (byte addresses on `cfg_addr`) are fixed as follows: window 0 base at 1Ch and limit at 20h, window 1 base at 24h and limit at 28h. In each register, bits 31:12 are read/write and reset to zero. Any other offset reads as zero.
- R2: Bits 11:0 of every base and limit register read back as zero, whatever data was written.
- R3: A configuration write changes only the byte lanes whose enable is set. `cfg_be[b]` covers bits 8b+7:8b, so lane 1 can change only bits 15:12.
- R4: A window claims an address when address[31:12] is at least the base page and at most the limit page. Both comparisons are unsigned, so the top of the window is limit[31:12] followed by FFFh.
- R5: Equal base and limit values give a window of exactly 4 KB, covering base through base+FFFh.
- R6: A window whose limit page is strictly below its base page claims no address.
- R7: While `mem_en` is low, the hit vector stays all zero.
- R8: When both windows claim an address, only `hit[0]` is set.
- R9: `hit` is registered. It reflects the address that was valid at the previous rising edge, and it is all zero after an edge at which `addr_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_be | input | 4 | Byte lane write enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` (combinational) |
| mem_en | input | 1 | Memory-space enable |
| addr_valid | input | 1 | Address strobe |
| addr | input | 32 | PCI memory address |
| hit | output | 2 | Registered per-window hit, bit 0 = window 0 |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4 KB granularity, two windows and an 8-bit configuration offset. These values make the full page range reachable. The bench therefore probes both the 7FFF_FFFFh/8000_0000h crossing, to expose any signed compare, and the exact first and last byte of each window. Two windows are enough to set up the overlapping case that exercises the priority rule, and a reversed-bounds case on one window while the other stays live.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int unsigned CFG_DW = 32;
  localparam int unsigned CFG_LANES = CFG_DW / 8;

  // Expand per-byte enables into a per-bit mask.
  function automatic logic [CFG_DW-1:0] lane_mask(input logic [CFG_LANES-1:0] be);
    logic [CFG_DW-1:0] m;
    for (int b = 0; b < CFG_LANES; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/mwd_win_regs.sv
module mwd_win_regs
  import mwd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_BITS = 12,
  parameter int unsigned CFG_AW    = 8,
  parameter logic [CFG_AW-1:0] LO_OFS = 8'h1C,
  parameter logic [CFG_AW-1:0] HI_OFS = 8'h20,
  localparam int unsigned PG_W = ADDR_W - GRAN_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_LANES-1:0] cfg_be,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  output logic [CFG_DW-1:0]    rd_data,
  output logic [PG_W-1:0]      lo_pg,
  output logic [PG_W-1:0]      hi_pg
);
  localparam logic [CFG_DW-1:0] FINE_MASK = (CFG_DW'(1) << GRAN_BITS) - CFG_DW'(1);

  // Only page bits are writable; fine bits never take data.
  function automatic logic [PG_W-1:0] merge(input logic [PG_W-1:0] old_pg,
                                            input logic [CFG_DW-1:0] wd,
                                            input logic [CFG_LANES-1:0] be);
    logic [CFG_DW-1:0] m, cur, nxt;
    m   = lane_mask(be) & ~FINE_MASK;
    cur = {old_pg, {GRAN_BITS{1'b0}}};
    nxt = (cur & ~m) | (wd & m);
    return nxt[CFG_DW-1:GRAN_BITS];
  endfunction

  logic wr_lo, wr_hi;
  assign wr_lo = cfg_wr && (cfg_addr == LO_OFS);
  assign wr_hi = cfg_wr && (cfg_addr == HI_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_pg <= '0;
      hi_pg <= '0;
    end else begin
      if (wr_lo) lo_pg <= merge(lo_pg, cfg_wdata, cfg_be);
      if (wr_hi) hi_pg <= merge(hi_pg, cfg_wdata, cfg_be);
    end
  end

  always_comb begin
    rd_data = '0;
    if (cfg_addr == LO_OFS)      rd_data = {lo_pg, {GRAN_BITS{1'b0}}};
    else if (cfg_addr == HI_OFS) rd_data = {hi_pg, {GRAN_BITS{1'b0}}};
  end
endmodule

// File: rtl/mwd_win_cmp.sv
module mwd_win_cmp #(
  parameter int unsigned PG_W = 20
) (
  input  logic [PG_W-1:0] addr_pg,
  input  logic [PG_W-1:0] lo_pg,
  input  logic [PG_W-1:0] hi_pg,
  output logic            win_off,
  output logic            in_win
);
  // Inclusive unsigned page range test; equal bounds is one page.
  function automatic logic page_in(input logic [PG_W-1:0] a,
                                   input logic [PG_W-1:0] lo,
                                   input logic [PG_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  assign win_off = hi_pg < lo_pg;
  assign in_win  = !win_off && page_in(addr_pg, lo_pg, hi_pg);
endmodule

// File: rtl/mwd_decoder.sv
module mwd_decoder
  import mwd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_BITS = 12,
  parameter int unsigned NUM_WIN   = 2,
  parameter int unsigned CFG_AW    = 8,
  parameter int unsigned FIRST_OFS = 'h1C,
  parameter int unsigned WIN_STEP  = 8,
  localparam int unsigned PG_W = ADDR_W - GRAN_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_LANES-1:0] cfg_be,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  output logic [CFG_DW-1:0]    cfg_rdata,
  input  logic                 mem_en,
  input  logic                 addr_valid,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_WIN-1:0]   hit
);
  logic [PG_W-1:0]   lo_pg   [NUM_WIN];
  logic [PG_W-1:0]   hi_pg   [NUM_WIN];
  logic [CFG_DW-1:0] rd_part [NUM_WIN];
  logic [NUM_WIN-1:0] in_win, win_off, win_sel;
  logic [PG_W-1:0]   addr_pg;
  logic              probe_live;

  assign addr_pg    = addr[ADDR_W-1:GRAN_BITS];
  assign probe_live = addr_valid && mem_en;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    mwd_win_regs #(
      .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .CFG_AW(CFG_AW),
      .LO_OFS(CFG_AW'(FIRST_OFS + i*WIN_STEP)),
      .HI_OFS(CFG_AW'(FIRST_OFS + i*WIN_STEP + 4))
    ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .rd_data(rd_part[i]),
      .lo_pg(lo_pg[i]), .hi_pg(hi_pg[i])
    );
    mwd_win_cmp #(.PG_W(PG_W)) u_cmp (
      .addr_pg(addr_pg), .lo_pg(lo_pg[i]), .hi_pg(hi_pg[i]),
      .win_off(win_off[i]), .in_win(in_win[i])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) cfg_rdata |= rd_part[i];
  end

  // Lowest-numbered claiming window wins.
  always_comb begin
    logic taken;
    taken   = 1'b0;
    win_sel = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (in_win[i] && !taken) begin
        win_sel[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          hit <= '0;
    else if (probe_live) hit <= win_sel;
    else                 hit <= '0;
  end

  // R7 R9: a hit only follows an enabled, valid address
  a_r9_hit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |-> $past(addr_valid && mem_en));

  // R8: never more than one window reported
  a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R4 R6: window 0 hit lies inside its live range
  a_r4_hit0_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |-> ($past(addr_pg) >= $past(lo_pg[0]) && $past(addr_pg) <= $past(hi_pg[0])));

  // R8: window 1 reported only where window 0 did not claim
  a_r8_w1_yields: assert property (@(posedge clk) disable iff (!rst_n)
    hit[1] |-> !($past(addr_pg) >= $past(lo_pg[0]) && $past(addr_pg) <= $past(hi_pg[0])));

  // R6: a reversed window is never reported
  a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_off[1]) |-> !hit[1]);
endmodule

// File: tb/mwd_decoder_bench.sv
module mwd_decoder_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        mem_en = 0;
  logic        addr_valid = 0;
  logic [31:0] addr = 0;
  logic [1:0]  hit;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mwd_decoder u_mwd_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_en(mem_en), .addr_valid(addr_valid), .addr(addr), .hit(hit)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check(req, cfg_rdata, exp);
  endtask

  // present one address for one edge, check the registered result
  task automatic probe(string req, logic [31:0] a, logic [1:0] exp);
    @(negedge clk);
    addr = a; addr_valid = 1;
    @(negedge clk);
    addr_valid = 0;
    check(req, {30'd0, hit}, {30'd0, exp});
  endtask

  task automatic t_reset;
    rd_check("R1", 8'h1C, 0); rd_check("R1", 8'h20, 0);
    rd_check("R1", 8'h24, 0); rd_check("R1", 8'h28, 0);
    check("R9", {30'd0, hit}, 0);
  endtask

  task automatic t_readback;
    wr(8'h20, 32'hFFFF_FFFF, 4'hF);
    rd_check("R2", 8'h20, 32'hFFFF_F000);
    wr(8'h1C, 32'h1234_5ABC, 4'hF);
    rd_check("R2", 8'h1C, 32'h1234_5000);
    rd_check("R1", 8'h2C, 0);
  endtask

  task automatic t_lanes;
    wr(8'h28, 32'hAABB_CCDD, 4'b0010);
    rd_check("R3", 8'h28, 32'h0000_C000);
    wr(8'h28, 32'hAABB_CCDD, 4'b1000);
    rd_check("R3", 8'h28, 32'hAA00_C000);
    wr(8'h28, 32'h0000_0000, 4'b0000);
    rd_check("R3", 8'h28, 32'hAA00_C000);
  endtask

  task automatic t_range;
    mem_en = 1;
    wr(8'h1C, 32'h1000_0000, 4'hF);
    wr(8'h20, 32'h1002_0000, 4'hF);
    wr(8'h24, 32'hFFFF_F000, 4'hF);
    wr(8'h28, 32'h0000_0000, 4'hF);
    probe("R4", 32'h1000_0000, 2'b01);
    probe("R4", 32'h1002_0FFF, 2'b01);
    probe("R4", 32'h1002_1000, 2'b00);
    probe("R4", 32'h0FFF_FFFF, 2'b00);
  endtask

  task automatic t_page;
    wr(8'h24, 32'h8000_0000, 4'hF);
    wr(8'h28, 32'h8000_0000, 4'hF);
    probe("R5", 32'h8000_0000, 2'b10);
    probe("R5", 32'h8000_0FFF, 2'b10);
    probe("R5", 32'h8000_1000, 2'b00);
    probe("R5", 32'h7FFF_FFFF, 2'b00);
  endtask

  task automatic t_off;
    wr(8'h20, 32'h0FFF_F000, 4'hF);
    probe("R6", 32'h1000_0000, 2'b00);
    probe("R6", 32'h0FFF_F000, 2'b00);
    probe("R6", 32'h8000_0800, 2'b10);
  endtask

  task automatic t_disable;
    mem_en = 0;
    probe("R7", 32'h8000_0000, 2'b00);
    mem_en = 1;
    probe("R7", 32'h8000_0000, 2'b10);
  endtask

  task automatic t_overlap;
    wr(8'h1C, 32'h2000_0000, 4'hF);
    wr(8'h20, 32'h2000_F000, 4'hF);
    wr(8'h24, 32'h2000_8000, 4'hF);
    wr(8'h28, 32'h2001_0000, 4'hF);
    probe("R8", 32'h2000_9000, 2'b01);
    probe("R8", 32'h2001_0000, 2'b10);
  endtask

  task automatic t_timing;
    @(negedge clk);
    addr = 32'h2000_0004; addr_valid = 1;
    #1 check("R9", {30'd0, hit}, 0);
    @(negedge clk);
    addr_valid = 0;
    check("R9", {30'd0, hit}, 2'b01);
    @(negedge clk);
    check("R9", {30'd0, hit}, 0);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_readback; t_lanes; t_range; t_page;
    t_off; t_disable; t_overlap; t_timing;
    finish_up;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
    finish_up;
  end
endmodule